// File: doc/BRIEF.md
# Round-Robin Marked-Slot Counter

This block is a scheduling pointer that moves directly to the next slot flagged in a run-time mask instead of counting by one. It is meant for round-robin service of a set of slots whose eligibility changes every cycle. Each slot owns one bit of the mark vector. On an advance the pointer hops to the closest flagged slot in circular order after its present position.

The search is split into two halves that both read the current pointer. One half keeps only the flagged slots above the pointer. The other keeps only the flagged slots at or below it. Each half runs a lowest-index search, and a hit in the upper half always wins. When nothing is flagged, the pointer stays put. A combinational flag reports whether any slot is flagged in the present cycle. The slot index width is a parameter; the default is 4 bits, which gives 16 slots.

Top module: `marked_slot_counter`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, the slot output is 0.
- R2: When advance is high and some mark bit above the current slot is set, the next slot is the smallest set index strictly greater than the current one. For example, at slot 2 with only bits 1 and 5 set, the next slot is 5.
- R3: When advance is high and no set bit lies above the current slot, the counter wraps to the lowest set index at or below the current slot.
- R4: When advance is high and the mark vector is all zero, the slot keeps its value.
- R5: When the only set bit is the current slot, an advance leaves the slot unchanged.
- R6: When advance is low, the slot holds its value whatever the mark vector shows.
- R7: The next slot is computed from the mark vector as sampled at that clock edge, even when the vector changes on every cycle.
- R8: The any-mark output is the OR of all mark bits and follows the mark input in the same cycle, without a clock.
- R9: From the highest slot (SLOTS-1), an advance with bit 0 set lands on slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| adv_en | input | 1 | Advance enable: when high, step to the next marked slot |
| mark | input | SLOTS | One eligibility bit per slot, bit i for slot i |
| slot | output | SLOT_W | Current slot index |
| any_mark | output | 1 | High when any mark bit is set |

## Verification
Three cases are the hardest to reach from the ports. One is the wrap, where every set bit sits at or below the pointer. Another is the case where the only set bit is the pointer's own slot. The third is a mask that changes on every cycle, so that a design using a stale mask would land elsewhere. The stimulus first steers the pointer to a chosen slot with a single-bit mask, then applies a crafted mask that leaves the bits above empty. A final run drives a different pseudo-random mask on every advancing cycle and compares each landing slot with an independently computed circular search.

// File: rtl/rr_mark_pkg.sv
package rr_mark_pkg;
  localparam int DEF_SLOT_W = 4;

  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_UPPER = 2'd1,
    SRC_WRAP  = 2'd2
  } next_src_e;
endpackage

// File: rtl/slot_rst_sync.sv
module slot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/slot_mask_split.sv
module slot_mask_split #(
  parameter int SLOT_W = 4,
  localparam int SLOTS = 1 << SLOT_W
) (
  input  logic [SLOTS-1:0]  mark,
  input  logic [SLOT_W-1:0] cur,
  output logic [SLOTS-1:0]  upper,
  output logic [SLOTS-1:0]  lower
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_bit
    localparam logic [SLOT_W-1:0] POS = SLOT_W'(g);
    assign upper[g] = mark[g] & (POS > cur);
    assign lower[g] = mark[g] & (POS <= cur);
  end
endmodule

// File: rtl/slot_ffs.sv
module slot_ffs #(
  parameter int SLOT_W = 4,
  localparam int SLOTS = 1 << SLOT_W
) (
  input  logic [SLOTS-1:0]  vec,
  output logic              found,
  output logic [SLOT_W-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (vec[i]) idx = SLOT_W'(i);
    end
  end
endmodule

// File: rtl/marked_slot_counter.sv
module marked_slot_counter
  import rr_mark_pkg::*;
#(
  parameter int SLOT_W = DEF_SLOT_W,
  localparam int SLOTS = 1 << SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  logic [SLOTS-1:0]  mark,
  output logic [SLOT_W-1:0] slot,
  output logic              any_mark
);
  logic              rst_n_s;
  logic [SLOTS-1:0]  upper_v, lower_v;
  logic              up_hit, lo_hit;
  logic [SLOT_W-1:0] up_idx, lo_idx;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              slot_en;
  next_src_e         src;

  slot_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  slot_mask_split #(.SLOT_W(SLOT_W)) i_split (
    .mark  (mark),
    .cur   (slot_q),
    .upper (upper_v),
    .lower (lower_v)
  );

  slot_ffs #(.SLOT_W(SLOT_W)) i_ffs_up (
    .vec   (upper_v),
    .found (up_hit),
    .idx   (up_idx)
  );

  slot_ffs #(.SLOT_W(SLOT_W)) i_ffs_lo (
    .vec   (lower_v),
    .found (lo_hit),
    .idx   (lo_idx)
  );

  always_comb begin
    if (up_hit)      src = SRC_UPPER;
    else if (lo_hit) src = SRC_WRAP;
    else             src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_UPPER: slot_d = up_idx;
      SRC_WRAP:  slot_d = lo_idx;
      default:   slot_d = slot_q;
    endcase
  end

  assign slot_en = adv_en && (src != SRC_HOLD);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     slot_q <= '0;
    else if (slot_en) slot_q <= slot_d;
  end

  assign slot     = slot_q;
  assign any_mark = |mark;
endmodule

// File: rtl/marked_slot_counter_chk.sv
module marked_slot_counter_chk #(
  parameter int SLOT_W = 4,
  localparam int SLOTS = 1 << SLOT_W
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              adv_en,
  input logic [SLOTS-1:0]  mark,
  input logic [SLOT_W-1:0] slot,
  input logic              any_mark
);
  logic              p_valid, p_adv;
  logic [SLOTS-1:0]  p_mark;
  logic [SLOT_W-1:0] p_slot;
  logic [SLOT_W:0]   d_new;
  logic              skipped;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      p_valid <= 1'b0;
      p_adv   <= 1'b0;
      p_mark  <= '0;
      p_slot  <= '0;
    end else begin
      p_valid <= 1'b1;
      p_adv   <= adv_en;
      p_mark  <= mark;
      p_slot  <= slot;
    end
  end

  always_comb begin
    logic [SLOT_W-1:0] dj;
    d_new   = (slot == p_slot) ? (SLOT_W+1)'(SLOTS) : {1'b0, slot - p_slot};
    skipped = 1'b0;
    for (int j = 0; j < SLOTS; j++) begin
      dj = SLOT_W'(j) - p_slot;
      if (p_mark[j] && (dj != '0) && ({1'b0, dj} < d_new)) skipped = 1'b1;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !adv_en |=> $stable(slot));  // R6

  AST_HOLD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (adv_en && !any_mark) |=> $stable(slot));  // R4

  AST_LANDS_MARKED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (adv_en && any_mark) |=> p_mark[slot]);  // R2

  AST_NEAREST_MARK: assert property (@(posedge clk) disable iff (!rst_n_s)
    (p_valid && p_adv && (p_mark != '0)) |-> !skipped);  // R3
endmodule

bind marked_slot_counter marked_slot_counter_chk #(.SLOT_W(SLOT_W)) i_chk (
  .clk      (clk),
  .rst_n_s  (rst_n_s),
  .adv_en   (adv_en),
  .mark     (mark),
  .slot     (slot),
  .any_mark (any_mark)
);

// File: tb/test_marked_slot_counter.sv
module test_marked_slot_counter;
  localparam int SLOT_W = 4;
  localparam int SLOTS  = 1 << SLOT_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              adv_en = 1'b0;
  logic [SLOTS-1:0]  mark = '0;
  logic [SLOT_W-1:0] slot;
  logic              any_mark;

  int n_cmp = 0;
  int n_bad = 0;
  logic [SLOT_W-1:0] exp_slot = '0;

  always #2.5 clk = ~clk;

  marked_slot_counter #(.SLOT_W(SLOT_W)) i_marked_slot_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_en   (adv_en),
    .mark     (mark),
    .slot     (slot),
    .any_mark (any_mark)
  );

  function automatic logic [SLOT_W-1:0] model(input logic [SLOT_W-1:0] cur,
                                              input logic [SLOTS-1:0] m);
    logic [SLOT_W-1:0] p;
    if (m == '0) return cur;
    for (int k = 1; k <= SLOTS; k++) begin
      p = cur + SLOT_W'(k);
      if (m[p]) return p;
    end
    return cur;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic [SLOTS-1:0] m, input string req);
    @(negedge clk);
    adv_en = a;
    mark   = m;
    if (a) exp_slot = model(exp_slot, m);
    @(posedge clk);
    #1;
    check(req, int'(slot), int'(exp_slot));
  endtask

  task automatic go_to(input logic [SLOT_W-1:0] s);
    step(1'b1, SLOTS'(1) << s, "R2 setup");
  endtask

  task automatic t_reset;
    #1;
    check("R1 during reset", int'(slot), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", int'(slot), 0);
    exp_slot = '0;
  endtask

  task automatic t_upper;
    go_to(4'd2);
    check("R2 reach 2", int'(slot), 2);
    step(1'b1, 16'h0022, "R2 example");
    check("R2 example value", int'(slot), 5);
    step(1'b1, 16'h8040, "R2 nearest above");
    check("R2 nearest value", int'(slot), 6);
  endtask

  task automatic t_wrap;
    go_to(4'd9);
    step(1'b1, 16'h020A, "R3 wrap lowest");
    check("R3 wrap value", int'(slot), 1);
    step(1'b1, 16'h0003, "R3 wrap to 0");
    check("R3 wrap to 0 value", int'(slot), 0);
  endtask

  task automatic t_empty;
    go_to(4'd7);
    step(1'b1, 16'h0000, "R4 empty hold");
    check("R4 empty value", int'(slot), 7);
  endtask

  task automatic t_self;
    go_to(4'd11);
    step(1'b1, 16'h0800, "R5 self only");
    step(1'b1, 16'h0800, "R5 self again");
    check("R5 self value", int'(slot), 11);
  endtask

  task automatic t_idle;
    go_to(4'd3);
    step(1'b0, 16'hFFFF, "R6 idle all marks");
    step(1'b0, 16'h0010, "R6 idle next mark");
    check("R6 idle value", int'(slot), 3);
  endtask

  task automatic t_top;
    go_to(4'd15);
    check("R9 at top", int'(slot), 15);
    step(1'b1, 16'h8001, "R9 wrap from top");
    check("R9 wrap value", int'(slot), 0);
  endtask

  task automatic t_dynamic;
    logic [SLOTS-1:0] m = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      m = {m[14:0], m[15] ^ m[13] ^ m[12] ^ m[10]};
      step(1'b1, (i % 7 == 3) ? (m & 16'h000F) : m, "R7 changing mask");
    end
  endtask

  task automatic t_flag;
    @(negedge clk);
    adv_en = 1'b0;
    mark = '0;
    #1;
    check("R8 flag zero", int'(any_mark), 0);
    for (int b = 0; b < SLOTS; b += 5) begin
      mark = SLOTS'(1) << b;
      #1;
      check("R8 flag single bit", int'(any_mark), 1);
    end
    mark = 16'h8000;
    #1;
    check("R8 flag top bit", int'(any_mark), 1);
  endtask

  initial begin
    #1000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_upper();
    t_wrap();
    t_empty();
    t_self();
    t_idle();
    t_top();
    t_dynamic();
    t_flag();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule